// File: doc/BRIEF.md
# H-Bridge Gate Control and Fault Latch

This block is the digital control core of a class-D output stage made of two half-bridges. For each half it turns a PWM input into a pair of gate enables, one for the high-side switch and one for the low-side switch. Each turn-on is held back by a programmable dead time. Each turn-off takes effect at once. An active-low mute input stops all switching and is also the way to recover from a fault. Two strap inputs must hold the one supported mode setting. Otherwise the stage stays in high impedance, which means all four enables are off.

Four synchronous fault flags come in: overcurrent, overtemperature warning, overtemperature error and gate-supply undervoltage. Every input except the mode straps passes through a two-flop synchronizer first. An overcurrent, overtemperature error or undervoltage event is latched and turns off both halves. The latch clears only when the mute input falls. Switching starts again only on the next rising edge of the mute input. Two active-low status outputs report the state of the chip. `hot_n` and `trip_n` together encode four conditions.

Top module: `hbridge_guard`

## Requirements
- R1: While the synchronized `mute_n` is low, all four gate enables are 0 for any PWM input. They go to 0 two clock edges after the pin falls.
- R2: With `mute_n` high, no fault, and valid mode pins, the steady enables `{a_hi,a_lo,b_hi,b_lo}` are as follows. `pwm_a`=0 and `pwm_b`=0 give 0101. A=0 and B=1 give 0110. A=1 and B=0 give 1001. A=1 and B=1 give 1010. A high PWM turns on the high side of its half, and a low PWM turns on the low side.
- R3: When a PWM input changes, the enable being released drops two edges after the pin changes. The opposite enable rises exactly `DEAD_CYC` cycles after that. A turn-on is never immediate.
- R4: The high-side and low-side enables of the same half are never 1 together.
- R5: A one-cycle pulse on `oc_flag`, `ote_flag` or `uv_flag` latches a fault. All enables stay 0 after the flag returns low, for as long as `mute_n` stays high.
- R6: The fault latch clears on the falling edge of `mute_n`. Switching starts again only after the next rising edge of `mute_n`, and then follows R2 and R3.
- R7: `trip_n` is 0 only while a fault is latched and `mute_n` is high. It is 1 while `mute_n` is low and in normal operation.
- R8: `hot_n` is 0 while `otw_flag` is high, or while an overtemperature error is latched with `mute_n` high. The pair `{hot_n,trip_n}` reads 00 for an overtemperature error, 01 for a warning only, 10 for an overcurrent or undervoltage error, and 11 for normal operation. A warning alone does not stop switching.
- R9: Switching is allowed only when `prot_mode`=2'b01 and `bridge_sel`=0. Any other setting forces all enables to 0 in the next cycle. Switching resumes once the valid setting returns.
- R10: PWM, mute and fault inputs pass through a `SYNC_LEN`-flop synchronizer (default 2). A fault flag that is high for a single sampled cycle is caught.
- R11: A fault arrives in the same synchronized cycle as the falling edge of `mute_n`. The fault wins: the latch stays set, and after the next rising edge all enables stay 0 with `trip_n` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low logic reset |
| pwm_a | input | 1 | PWM command, half-bridge A |
| pwm_b | input | 1 | PWM command, half-bridge B |
| mute_n | input | 1 | Active-low mute and fault-recovery input |
| prot_mode | input | 2 | Protection-mode strap pair; only 2'b01 is valid |
| bridge_sel | input | 1 | Output-configuration strap; only 0 is valid |
| oc_flag | input | 1 | Overcurrent event |
| otw_flag | input | 1 | Overtemperature warning |
| ote_flag | input | 1 | Overtemperature error |
| uv_flag | input | 1 | Gate-supply undervoltage |
| a_hi | output | 1 | High-side enable, half A |
| a_lo | output | 1 | Low-side enable, half A |
| b_hi | output | 1 | High-side enable, half B |
| b_lo | output | 1 | Low-side enable, half B |
| trip_n | output | 1 | Active-low protection status |
| hot_n | output | 1 | Active-low temperature status |

## Verification
The clear of the fault latch on the falling mute edge and the setting of the latch by a new fault can land in the same cycle. The bench provokes this by driving `mute_n` low and pulsing `oc_flag` on the same clock. Both inputs pass through synchronizers of equal depth, so they reach the latch together. The result is judged after the next rising mute edge: the enables must stay off and `trip_n` must read 0. A second mute toggle with no fault must then bring back the normal bridge pattern.

// File: rtl/hbridge_guard.sv
module hbridge_guard #(
  parameter int DEAD_CYC = 4,
  parameter int SYNC_LEN = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwm_a,
  input  logic       pwm_b,
  input  logic       mute_n,
  input  logic [1:0] prot_mode,
  input  logic       bridge_sel,
  input  logic       oc_flag,
  input  logic       otw_flag,
  input  logic       ote_flag,
  input  logic       uv_flag,
  output logic       a_hi,
  output logic       a_lo,
  output logic       b_hi,
  output logic       b_lo,
  output logic       trip_n,
  output logic       hot_n
);
  localparam int NIN = 7;
  localparam int CW  = $clog2(DEAD_CYC + 1);

  logic [SYNC_LEN-1:0][NIN-1:0] sr;
  logic [NIN-1:0] s;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sr <= '0;
    else        sr <= {sr[SYNC_LEN-2:0], {uv_flag, ote_flag, otw_flag, oc_flag, mute_n, pwm_b, pwm_a}};
  assign s = sr[SYNC_LEN-1];

  logic [1:0] pwm_s;
  logic run_s, oc_s, otw_s, ote_s, uv_s;
  assign pwm_s = s[1:0];
  assign run_s = s[2];
  assign oc_s  = s[3];
  assign otw_s = s[4];
  assign ote_s = s[5];
  assign uv_s  = s[6];

  logic run_q, ote_lat, ocuv_lat, en_q;
  logic rise, fall, mode_ok, fault_now, live;
  assign rise      = run_s & ~run_q;
  assign fall      = ~run_s & run_q;
  assign mode_ok   = (prot_mode == 2'b01) && !bridge_sel;
  assign fault_now = oc_s | ote_s | uv_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run_q    <= 1'b0;
      ote_lat  <= 1'b0;
      ocuv_lat <= 1'b0;
      en_q     <= 1'b0;
    end else begin
      run_q    <= run_s;
      ote_lat  <= (ote_lat & ~fall) | ote_s;
      ocuv_lat <= (ocuv_lat & ~fall) | oc_s | uv_s;
      if (!run_s || ote_lat || ocuv_lat || fault_now) en_q <= 1'b0;
      else if (rise)                                  en_q <= 1'b1;
    end

  assign live = en_q & run_s & mode_ok & ~fault_now;

  logic [1:0] w_hi, w_lo, on_hi, on_lo;
  assign w_hi = {2{live}} & pwm_s;
  assign w_lo = {2{live}} & ~pwm_s;

  for (genvar i = 0; i < 2; i++) begin : g_half
    logic hq, lq, ph, pl;
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        hq <= 1'b0; lq <= 1'b0; ph <= 1'b0; pl <= 1'b0; cnt <= '0;
      end else begin
        ph <= w_hi[i];
        pl <= w_lo[i];
        if (!(w_hi[i] | w_lo[i])) begin
          hq <= 1'b0; lq <= 1'b0; cnt <= '0;
        end else if (w_hi[i] != ph || w_lo[i] != pl) begin
          hq <= 1'b0; lq <= 1'b0; cnt <= CW'(1);
        end else if (!(hq | lq)) begin
          if (cnt == CW'(DEAD_CYC - 1)) begin
            hq <= w_hi[i];
            lq <= w_lo[i];
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
      end
    assign on_hi[i] = hq & w_hi[i];
    assign on_lo[i] = lq & w_lo[i];
  end

  assign a_hi = on_hi[0];
  assign a_lo = on_lo[0];
  assign b_hi = on_hi[1];
  assign b_lo = on_lo[1];

  assign trip_n = ~(run_s & (ote_lat | ocuv_lat));
  assign hot_n  = ~(otw_s | (run_s & ote_lat));

  a_r1_mute_off: assert property (@(posedge clk) disable iff (!rst_n)
    !run_s |-> !(a_hi || a_lo || b_hi || b_lo));
  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_hi && a_lo) && !(b_hi && b_lo));
  a_r3_dead_a: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(a_hi) |-> $past(!a_lo)) and ($rose(a_lo) |-> $past(!a_hi)));
  a_r3_dead_b: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(b_hi) |-> $past(!b_lo)) and ($rose(b_lo) |-> $past(!b_hi)));
  a_r5_latched_off: assert property (@(posedge clk) disable iff (!rst_n)
    (ote_lat || ocuv_lat) |-> !(a_hi || a_lo || b_hi || b_lo));
  a_r6_resume_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> $past(run_s && !run_q));
  a_r7_trip_high_in_mute: assert property (@(posedge clk) disable iff (!rst_n)
    !run_s |-> trip_n);
  a_r9_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_ok |-> !(a_hi || a_lo || b_hi || b_lo));
endmodule

// File: tb/tb_hbridge_guard.sv
module tb_hbridge_guard;
  localparam int DEAD = 4;
  localparam int SETTLE = DEAD + 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, pwm_a, pwm_b, mute_n, bridge_sel;
  logic [1:0] prot_mode;
  logic oc_flag, otw_flag, ote_flag, uv_flag;
  logic a_hi, a_lo, b_hi, b_lo, trip_n, hot_n;

  hbridge_guard #(.DEAD_CYC(DEAD), .SYNC_LEN(2)) dut (
    .clk(clk), .rst_n(rst_n), .pwm_a(pwm_a), .pwm_b(pwm_b), .mute_n(mute_n),
    .prot_mode(prot_mode), .bridge_sel(bridge_sel), .oc_flag(oc_flag),
    .otw_flag(otw_flag), .ote_flag(ote_flag), .uv_flag(uv_flag),
    .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo),
    .trip_n(trip_n), .hot_n(hot_n));

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [3:0] outs();
    return {a_hi, a_lo, b_hi, b_lo};
  endfunction

  // gap and overlap monitor
  bit mon = 0;
  int gap_a = 0, gap_b = 0, gap_seen = 0, gap_bad = 0, overlap = 0;
  logic last_a = 0, last_b = 0;
  always @(negedge clk) begin
    if ((a_hi && a_lo) || (b_hi && b_lo)) overlap++;
    if (a_hi || a_lo) begin
      if (mon && gap_a > 0 && last_a != a_hi) begin gap_seen++; if (gap_a != DEAD) gap_bad++; end
      gap_a = 0; last_a = a_hi;
    end else gap_a++;
    if (b_hi || b_lo) begin
      if (mon && gap_b > 0 && last_b != b_hi) begin gap_seen++; if (gap_b != DEAD) gap_bad++; end
      gap_b = 0; last_b = b_hi;
    end else gap_b++;
  end

  task automatic t_reset();
    rst_n = 0; pwm_a = 0; pwm_b = 0; mute_n = 0; prot_mode = 2'b01; bridge_sel = 0;
    oc_flag = 0; otw_flag = 0; ote_flag = 0; uv_flag = 0;
    tick(3);
    chk("R1 reset enables", outs(), 4'b0000);
    chk("R7 reset status", {hot_n, trip_n}, 2'b11);
    rst_n = 1;
    tick(SETTLE);
    chk("R1 muted after reset", outs(), 4'b0000);
  endtask

  task automatic t_table();
    mute_n = 1;
    tick(SETTLE);
    chk("R2 A0 B0", outs(), 4'b0101);
    pwm_b = 1; tick(SETTLE);
    chk("R2 A0 B1", outs(), 4'b0110);
    pwm_a = 1; pwm_b = 0; tick(SETTLE);
    chk("R2 A1 B0", outs(), 4'b1001);
    pwm_b = 1; tick(SETTLE);
    chk("R2 A1 B1", outs(), 4'b1010);
    chk("R8 normal status", {hot_n, trip_n}, 2'b11);
    pwm_a = 0; pwm_b = 0; tick(SETTLE);
  endtask

  task automatic t_latency();
    pwm_a = 1;
    tick(1);
    chk("R10 one edge no change", outs(), 4'b0101);
    tick(1);
    chk("R3 immediate turn-off", outs(), 4'b0001);
    tick(DEAD - 1);
    chk("R3 still in dead time", outs(), 4'b0001);
    tick(1);
    chk("R3 turn-on after dead time", outs(), 4'b1001);
    pwm_a = 0; tick(SETTLE);
  endtask

  task automatic t_deadtime();
    mon = 1;
    for (int k = 0; k < 6; k++) begin
      pwm_a = ~pwm_a; tick(3); pwm_b = ~pwm_b; tick(12);
    end
    mon = 0;
    chk("R3 dead gaps counted", 8'(gap_seen), 8'd12);
    chk("R3 dead gap length", 8'(gap_bad), 8'd0);
    chk("R4 no overlap", 8'(overlap), 8'd0);
    pwm_a = 0; pwm_b = 0; tick(SETTLE);
  endtask

  task automatic t_mute();
    mute_n = 0;
    tick(2);
    chk("R1 mute off in two edges", outs(), 4'b0000);
    for (int k = 0; k < 4; k++) begin
      pwm_a = k[0]; pwm_b = k[1]; tick(6);
      chk("R1 mute ignores pwm", outs(), 4'b0000);
    end
    chk("R7 trip high in mute", {7'd0, trip_n}, 8'd1);
    pwm_a = 0; pwm_b = 0; mute_n = 1; tick(SETTLE);
    chk("R6 resume after mute", outs(), 4'b0101);
  endtask

  task automatic t_fault(int kind);
    if (kind == 0) oc_flag = 1; else if (kind == 1) uv_flag = 1; else ote_flag = 1;
    tick(1);
    oc_flag = 0; uv_flag = 0; ote_flag = 0;
    tick(4);
    chk("R5 fault forces off", outs(), 4'b0000);
    chk("R8 fault code", {hot_n, trip_n}, (kind == 2) ? 2'b00 : 2'b10);
    tick(30);
    chk("R5 latch holds", outs(), 4'b0000);
    chk("R7 trip stays low", {7'd0, trip_n}, 8'd0);
    mute_n = 0; tick(4);
    chk("R7 trip forced high", {hot_n, trip_n}, 2'b11);
    chk("R6 still off in mute", outs(), 4'b0000);
    mute_n = 1; tick(SETTLE);
    chk("R6 resume after toggle", outs(), 4'b0101);
    chk("R6 status clear", {hot_n, trip_n}, 2'b11);
  endtask

  task automatic t_warn();
    otw_flag = 1; tick(4);
    chk("R8 warning code", {hot_n, trip_n}, 2'b01);
    pwm_a = 1; tick(SETTLE);
    chk("R8 warning keeps switching", outs(), 4'b1001);
    otw_flag = 0; pwm_a = 0; tick(SETTLE);
    chk("R8 warning cleared", {hot_n, trip_n}, 2'b11);
  endtask

  task automatic t_mode();
    for (int k = 0; k < 4; k++) begin
      if (k == 1) continue;
      prot_mode = 2'(k); tick(1);
      chk("R9 bad protection mode off", outs(), 4'b0000);
    end
    prot_mode = 2'b01; bridge_sel = 1; tick(1);
    chk("R9 bad bridge select off", outs(), 4'b0000);
    bridge_sel = 0; tick(SETTLE);
    chk("R9 valid mode resumes", outs(), 4'b0101);
  endtask

  task automatic t_same_cycle();
    mute_n = 0; oc_flag = 1;
    tick(1);
    oc_flag = 0;
    tick(6);
    mute_n = 1;
    tick(SETTLE);
    chk("R11 fault beats clear", outs(), 4'b0000);
    chk("R11 trip low after rise", {7'd0, trip_n}, 8'd0);
    mute_n = 0; tick(4); mute_n = 1; tick(SETTLE);
    chk("R11 recovers on next toggle", outs(), 4'b0101);
  endtask

  initial begin
    t_reset();
    t_table();
    t_latency();
    t_deadtime();
    t_mute();
    t_fault(0);
    t_fault(1);
    t_fault(2);
    t_warn();
    t_mode();
    t_same_cycle();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule